// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI bus master that a processor drives through three 16-bit registers on a simple synchronous bus: one register holds data, one holds control and one holds status. Software sets the word size, the clock mode and the bit-rate divider in the control register. It enables the block, then writes a word to the data register. The block shifts that word out on `mosi`, most significant bit first, while it shifts a word of the same size in from `miso`. When the last bit is in, the received word is copied to a one-word receive buffer and a buffer-full flag is raised.

Software either polls the status register or enables one or both interrupt sources. One source is the buffer-full flag. The other is the idle shifter, which means a new word may be written. Reading the data register returns the buffered word and clears the full flag. Chip-select lines are generated outside this block.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the control register reads 0x0000, the status register reads 0x0000, and `sck`, `mosi` and `irq` are all low.
- R2: The data register is at bus offset 0x0, the control register at 0x2 and the status register at 0x4. All sixteen control bits read back exactly as written.
- R3: When control bit 2 is clear, a data write sends bits 7:0 of the written value MSB first. The received byte is returned in bits 7:0 of a data read, and bits 15:8 read as zero.
- R4: When control bit 2 is set, a data write sends all 16 bits MSB first, so the upper byte goes out first. The received word is returned whole, with the first bit received in bit 15.
- R5: Control bit 7 sets the idle level of `sck`. If control bit 8 is clear, `miso` is sampled on the first edge of each bit and `mosi` changes on the second edge. If bit 8 is set, `mosi` changes on the first edge and `miso` is sampled on the second edge. A word of B bits gives exactly 2·B edges, and `sck` returns to its idle level afterwards.
- R6: With divider value N in control bits 15:9, each half period of `sck` lasts N+1 clock cycles. Status bit 0 (busy) is set for exactly 2·B·(N+1) cycles, counted from the clock edge that accepts the data write.
- R7: Status bit 1 (receive full) is set when a word completes. A data read clears it. A status read leaves it unchanged.
- R8: A data write while busy is set is dropped. The word in flight is not changed, and the transfer does not get longer.
- R9: While control bit 0 is clear, a data write starts nothing: busy stays low, `sck` holds its idle level, and the receive buffer and its flag are unchanged.
- R10: `irq` is high when control bit 0 is set and either (control bit 5 is set and receive full is set) or (control bit 6 is set and busy is clear). Otherwise `irq` is low.
- R11: A completed word overwrites an unread one in the receive buffer. No error flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; side effects happen at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong edge count or a wrong divider count shows up in the same transfer: the bench counts the `sck` edges and the busy cycles, and either count comes out off by at least one. Picking the wrong sample or shift edge puts the bits out of step by one position. The bench's serial model on the far side of the bus catches that in the same word, and the data read that follows catches it too. A fault in the receive buffer or its flag shows up at the first data or status read after the word completes, and an `irq` that disagrees with the flags shows up in the next cycle.

// File: rtl/spih_pkg.sv
// Package: register offsets, control and status bit positions, and the
// decoded configuration type shared by the SPI master's submodules.
// Assumes a 16-bit register bus addressed by byte offset.
package spih_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned HALF_W = REG_W / 2;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DIV_W  = 7;
    localparam int unsigned EDGE_W = $clog2(2 * REG_W);

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_WIDE  = 2;
    localparam int unsigned CB_IE_RX = 5;
    localparam int unsigned CB_IE_TX = 6;
    localparam int unsigned CB_CPOL  = 7;
    localparam int unsigned CB_CPHA  = 8;
    localparam int unsigned CB_DIV   = 9;

    localparam int unsigned SB_BUSY = 0;
    localparam int unsigned SB_RXF  = 1;

    typedef struct packed {
        logic             en;
        logic             wide;
        logic             ie_rx;
        logic             ie_tx;
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
    } spih_cfg_t;
endpackage

// File: rtl/spih_clkgen.sv
// Half-period timer: while run is high, pulses tick once every div+1
// cycles. Each tick marks one serial clock edge. Assumes div is held
// constant during a transfer.
module spih_clkgen #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count cycles within the current half period; restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!run || (tick == (div == '0))));  // R6
endmodule

// File: rtl/spih_shift.sv
// Shift engine: loads a word on start, then on each timer tick toggles
// the serial clock and either shifts out or samples, according to the
// phase setting. It flags the last edge with done and presents the
// assembled received word. Assumes the mode bits stay put while busy.
module spih_shift
    import spih_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wide,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             start,
    input  logic [REG_W-1:0] wdata,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] rx_word,
    output logic             sck,
    output logic             mosi
);
    logic              ph;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] last_edge;
    logic [REG_W-1:0]  txsr;
    logic [REG_W-1:0]  rxsr;
    logic [REG_W-1:0]  rx_next;
    logic [REG_W-1:0]  rx_full_w;
    logic [REG_W-1:0]  aligned;
    logic              mosi_q;
    logic              lead;
    logic              samp;
    logic              shft;

    // Word alignment, edge classification and the final edge index.
    always_comb begin
        aligned   = wide ? wdata : {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
        last_edge = wide ? EDGE_W'(2 * REG_W - 1) : EDGE_W'(REG_W - 1);
        lead      = ~edge_cnt[0];
        samp      = tick && (lead ^ cpha);
        shft      = tick && !(lead ^ cpha);
        rx_next   = {rxsr[REG_W-2:0], miso};
    end

    // Load, shift, sample and end-of-word sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy     <= 1'b0;
            ph       <= 1'b0;
            edge_cnt <= '0;
            txsr     <= '0;
            rxsr     <= '0;
            mosi_q   <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                ph       <= 1'b0;
                edge_cnt <= '0;
                rxsr     <= '0;
                if (!cpha) begin
                    mosi_q <= aligned[REG_W-1];
                    txsr   <= aligned << 1;
                end else begin
                    txsr   <= aligned;
                end
            end
        end else if (tick) begin
            ph       <= ~ph;
            edge_cnt <= edge_cnt + 1'b1;
            if (samp) begin
                rxsr <= rx_next;
            end
            if (shft) begin
                mosi_q <= txsr[REG_W-1];
                txsr   <= txsr << 1;
            end
            if (edge_cnt == last_edge) begin
                busy <= 1'b0;
            end
        end
    end

    // The received word, including a sample taken on the final edge.
    always_comb begin
        rx_full_w = samp ? rx_next : rxsr;
        rx_word   = wide ? rx_full_w : {{HALF_W{1'b0}}, rx_full_w[HALF_W-1:0]};
    end

    assign done = busy && tick && (edge_cnt == last_edge);
    assign sck  = cpol ^ ph;
    assign mosi = mosi_q;

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));  // R5
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start && !busy) |=> busy);  // R6
    AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && start && en) |=> $stable(txsr));  // R8
endmodule

// File: rtl/spih_regs.sv
// Register file: control register, one-word receive buffer with its
// full flag, read-data mux, start strobe and interrupt logic. Assumes
// single-cycle bus strobes; the side effects of a read happen at the
// clock edge.
module spih_regs
    import spih_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [REG_W-1:0]  rx_word,
    output spih_cfg_t         cfg,
    output logic              start,
    output logic              rx_full,
    output logic              irq
);
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] rxbuf;
    logic             rd_data;

    assign rd_data = rd && (addr == OFS_DATA);

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr && (addr == OFS_CTRL)) begin
            ctrl <= wdata;
        end
    end

    // Receive buffer capture and full-flag set/clear; completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf   <= '0;
            rx_full <= 1'b0;
        end else begin
            if (done) begin
                rxbuf <= rx_word;
            end
            if (done) begin
                rx_full <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end
        end
    end

    // Field decode of the control register.
    always_comb begin
        cfg.en    = ctrl[CB_EN];
        cfg.wide  = ctrl[CB_WIDE];
        cfg.ie_rx = ctrl[CB_IE_RX];
        cfg.ie_tx = ctrl[CB_IE_TX];
        cfg.cpol  = ctrl[CB_CPOL];
        cfg.cpha  = ctrl[CB_CPHA];
        cfg.div   = ctrl[CB_DIV +: DIV_W];
    end

    // Read-data mux by offset.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DATA: rdata = rxbuf;
            OFS_CTRL: rdata = ctrl;
            OFS_STAT: begin
                rdata[SB_BUSY] = busy;
                rdata[SB_RXF]  = rx_full;
            end
            default:  rdata = '0;
        endcase
    end

    assign start = wr && (addr == OFS_DATA) && cfg.en;
    assign irq   = cfg.en && ((cfg.ie_rx && rx_full) || (cfg.ie_tx && !busy));

    AST_RXF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);  // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !rx_full);  // R7
endmodule

// File: rtl/spi_host_regs.sv
// Top: SPI master with a 16-bit register interface. Connects the
// register file, the half-period timer and the shift engine. Assumes
// chip selects are driven elsewhere.
module spi_host_regs
    import spih_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    spih_cfg_t        cfg;
    logic             start;
    logic             busy;
    logic             done;
    logic             tick;
    logic             rx_full;
    logic [REG_W-1:0] rx_word;

    spih_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_word),
        .cfg     (cfg),
        .start   (start),
        .rx_full (rx_full),
        .irq     (irq)
    );

    spih_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg.div),
        .tick  (tick)
    );

    spih_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg.en),
        .wide    (cfg.wide),
        .cpol    (cfg.cpol),
        .cpha    (cfg.cpha),
        .start   (start),
        .wdata   (bus_wdata),
        .tick    (tick),
        .miso    (miso),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_word),
        .sck     (sck),
        .mosi    (mosi)
    );

    AST_WORD_END_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cfg.en) |-> rx_full);  // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !irq);  // R10
endmodule

// File: tb/sim_spi_host_regs.sv
// Bench: sweeps clock modes, word sizes and dividers against a serial
// model on the far side of the bus, then checks the register, interrupt
// and drop corner cases.
module sim_spi_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'h4;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, irq;
    logic        miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    // Serial model state
    logic        xfer_on = 1'b0;
    logic        b_cpol = 1'b0, b_cpha = 1'b0;
    logic [15:0] s_out = '0, s_in = '0;
    int          s_idx = 0;
    int          edges = 0;

    always #10 clk = ~clk;

    spi_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    // Far-side model: sample mosi on sample edges, present next bit on shift edges.
    always @(sck) begin
        if (xfer_on) begin
            edges = edges + 1;
            if ((sck != b_cpol) ^ b_cpha) begin
                s_in = {s_in[14:0], mosi};
            end else begin
                if (s_idx < 16) miso = s_out[15 - s_idx];
                s_idx = s_idx + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'h4;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 3'h4;
    endtask

    // Full transfer: configure, start, count busy cycles, check the results.
    task automatic run_xfer(input logic pol, input logic pha, input logic wid,
                            input int dv, input logic [15:0] txw, input logic [15:0] slvw,
                            input logic inject, input logic do_read, input logic [1:0] ie);
        logic [15:0] ctl, rv;
        int bits, cnt;
        logic bz;
        bits = wid ? 16 : 8;
        ctl  = (16'(dv) << 9) | (16'(pha) << 8) | (16'(pol) << 7) | (16'(ie) << 5)
             | (16'(wid) << 2) | 16'h0001;
        bus_write(3'h2, ctl);
        b_cpol = pol; b_cpha = pha; edges = 0; s_in = '0;
        s_out = wid ? slvw : {slvw[7:0], 8'h00};
        if (!pha) begin miso = s_out[15]; s_idx = 1; end else s_idx = 0;
        xfer_on = 1'b1;
        bus_write(3'h0, txw);
        cnt = 0;
        forever begin
            bus_wr = 1'b0; bus_addr = 3'h4;
            #1 bz = bus_rdata[0];
            if (!bz || cnt > 100000) break;
            cnt++;
            if (inject && cnt == 2) begin
                bus_addr = 3'h0; bus_wdata = 16'hC35A; bus_wr = 1'b1;
            end
            @(negedge clk);
        end
        xfer_on = 1'b0;
        chk("R6 busy cycles", cnt, 2 * bits * (dv + 1));
        chk("R5 edge count", edges, 2 * bits);
        chk("R5 idle sck", sck, pol);
        chk(wid ? "R4 mosi word" : "R3 mosi byte", wid ? s_in : {8'h00, s_in[7:0]},
            wid ? txw : {8'h00, txw[7:0]});
        if (inject) chk("R8 dropped write", wid ? s_in : {8'h00, s_in[7:0]},
            wid ? txw : {8'h00, txw[7:0]});
        bus_read(3'h4, rv);
        chk("R7 rx full set", rv[1], 1'b1);
        if (do_read) begin
            bus_read(3'h0, rv);
            chk(wid ? "R4 rx word" : "R3 rx byte", rv, wid ? slvw : {8'h00, slvw[7:0]});
            bus_read(3'h4, rv);
            chk("R7 rx full cleared", rv[1], 1'b0);
        end
    endtask

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(3'h2, rv); chk("R1 ctrl reset", rv, 16'h0000);
        bus_read(3'h4, rv); chk("R1 stat reset", rv, 16'h0000);
        chk("R1 sck", sck, 1'b0); chk("R1 mosi", mosi, 1'b0); chk("R1 irq", irq, 1'b0);
        // R2 offsets and read-back
        bus_write(3'h2, 16'hFE9A); bus_read(3'h2, rv); chk("R2 ctrl readback", rv, 16'hFE9A);
        bus_write(3'h2, 16'h0000); bus_read(3'h2, rv); chk("R2 ctrl cleared", rv, 16'h0000);
        // Sweep: modes x widths x dividers (R3 R4 R5 R6 R7)
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int d = 0; d < 3; d++) begin
                    run_xfer(m[1], m[0], w[0], (d == 2) ? 3 : d,
                             16'hA5C3 ^ 16'(m * 37 + w * 11 + d * 5),
                             16'h3C96 ^ 16'(m * 53 + w * 7 + d * 19), 1'b0, 1'b1, 2'b00);
                end
            end
        end
        run_xfer(1'b1, 1'b0, 1'b1, 127, 16'h8001, 16'h7FFE, 1'b0, 1'b1, 2'b00); // R6 max divider
        // R8 write while busy is dropped
        run_xfer(1'b0, 1'b1, 1'b1, 2, 16'h1234, 16'h4321, 1'b1, 1'b1, 2'b00);
        run_xfer(1'b1, 1'b1, 1'b0, 1, 16'h00B7, 16'h004E, 1'b1, 1'b1, 2'b00);
        // R7 status read keeps flag; R11 overwrite of unread word
        run_xfer(1'b0, 1'b0, 1'b1, 0, 16'h1111, 16'hBEEF, 1'b0, 1'b0, 2'b00);
        bus_read(3'h4, rv); chk("R7 status read keeps flag", rv[1], 1'b1);
        run_xfer(1'b0, 1'b0, 1'b1, 0, 16'h2222, 16'hCAFE, 1'b0, 1'b0, 2'b00);
        bus_read(3'h0, rv); chk("R11 overwrite", rv, 16'hCAFE);
        // R9 disabled: data write ignored, idle level held
        bus_write(3'h2, 16'h0184);
        edges = 0; xfer_on = 1'b1;
        bus_write(3'h0, 16'h5555);
        repeat (20) @(negedge clk);
        xfer_on = 1'b0;
        bus_read(3'h4, rv); chk("R9 no busy no rxfull", rv, 16'h0000);
        chk("R9 sck idle", sck, 1'b1); chk("R9 no edges", edges, 0);
        bus_read(3'h0, rv); chk("R9 rx buffer kept", rv, 16'hCAFE);
        // R10 interrupt gating
        bus_write(3'h2, 16'h0041); #1 chk("R10 tx ready irq", irq, 1'b1);
        bus_write(3'h2, 16'h0021); #1 chk("R10 rx irq empty", irq, 1'b0);
        run_xfer(1'b0, 1'b0, 1'b0, 0, 16'h005A, 16'h00A5, 1'b0, 1'b0, 2'b01);
        #1 chk("R10 rx irq full", irq, 1'b1);
        bus_write(3'h2, 16'h0060); #1 chk("R10 irq off when disabled", irq, 1'b0);
        bus_write(3'h2, 16'h0021); #1 chk("R10 irq re-enabled", irq, 1'b1);
        bus_read(3'h0, rv); #1 chk("R10 irq after data read", irq, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule